// File: doc/BRIEF.md
# Panel Power and Backlight Sequencer

This block orders the bring-up and shutdown of a flat panel. It drives three enables: the panel logic supply, the drivers of the video interface signals (when that enable is low, the signals must be held low or left floating), and the backlight lamp. The enables always nest. The supply comes up first, then the signals, then the lamp. Shutdown runs in the reverse order, and every step waits out its minimum delay.

All delays are whole milliseconds. A prescaler divides the clock by a parameter, so a bench can run a scaled-down version of the same sequence. Power-on and power-off requests are one-cycle pulses. A request that arrives while the sequencer cannot act on it is dropped, not stored.

While the supply ramps, the block waits for the supply-good input. If supply-good does not come within the rise window, the block removes the supply and raises a fault flag. A power-off request during bring-up aborts it and unwinds only the steps that have already been taken.

Top module: `panel_pwr_seq`

## Requirements
- R1: During reset and directly after it, all three enables and `fault` are 0. After reset is released, `vdd_en` stays low for VDD_OFF_MIN_MS·CLK_KHZ+1 cycles before any power-on request is accepted.
- R2: A `pwr_on_req` pulse in the idle state raises `vdd_en` on the next cycle. `sig_en` and `lamp_en` stay low at that point.
- R3: `sig_en` rises on the cycle after `supply_good` is sampled high while the supply is ramping. `sig_en` is never high while `vdd_en` is low.
- R4: `lamp_en` rises exactly LAMP_ON_DLY_MS·CLK_KHZ+1 cycles after `sig_en` rises. `lamp_en` is never high while `sig_en` is low.
- R5: A `pwr_off_req` pulse with the lamp on drops `lamp_en` on the next cycle. `sig_en` then stays high for exactly LAMP_OFF_LEAD_MS·CLK_KHZ+1 cycles.
- R6: `sig_en` falls one cycle before `vdd_en` falls. The two never fall together.
- R7: Once `vdd_en` falls, it stays low for VDD_OFF_MIN_MS·CLK_KHZ+1 cycles. A power-on request held high throughout sees `vdd_en` return after exactly VDD_OFF_MIN_MS·CLK_KHZ+2 low cycles. A power-on pulse during this hold is dropped.
- R8: If `supply_good` stays low for SUPPLY_RISE_MS·CLK_KHZ+1 cycles of ramp, `vdd_en` drops and `fault` rises on the same cycle. `fault` is held until the next accepted power-on request clears it, and it is only ever high while `vdd_en` is low.
- R9: A `pwr_off_req` during the supply ramp drops `vdd_en` on the next cycle, without raising `fault`.
- R10: A `pwr_off_req` while the sequencer waits for the lamp delay drops `sig_en` on the next cycle and `vdd_en` on the cycle after. The lamp is never enabled.
- R11: Requests during shutdown have no effect. This covers the lamp-off wait and the signal-drop cycle. In the idle state, an off pulse that arrives together with an on pulse wins, and the supply stays off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, CLK_KHZ cycles per millisecond |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwr_on_req | input | 1 | One-cycle power-on request |
| pwr_off_req | input | 1 | One-cycle power-off request, wins over a simultaneous on request |
| supply_good | input | 1 | Panel supply has reached its valid level |
| vdd_en | output | 1 | Panel logic supply enable |
| sig_en | output | 1 | Video interface signal drive enable |
| lamp_en | output | 1 | Backlight lamp enable |
| fault | output | 1 | Supply failed to come up within the rise window |

## Verification
The bound checker watches the nesting on every cycle: no signals without the supply, no lamp without signals, and no supply drop in the same cycle as the signals. It counts cycles to confirm the minimum lamp-on delay, the lamp-off lead and the supply-off time at each transition. It also checks that the signals only rise after supply-good and that `fault` only appears with the supply off.

Only the bench scenarios can show the rest. Those are the exact dwell lengths, the handling of requests that must be dropped (during the hold, during shutdown, and on and off together), each abort path, and the fault being set and later cleared.

// File: rtl/pps_pkg.sv
package pps_pkg;
   typedef enum logic [2:0] {
      ST_HOLD = 3'd0,   // supply off, minimum off time running
      ST_IDLE = 3'd1,   // supply off, ready for a request
      ST_RAMP = 3'd2,   // supply enabled, waiting for supply good
      ST_SIGW = 3'd3,   // signals driven, lamp delay running
      ST_ON   = 3'd4,   // fully on
      ST_LOFF = 3'd5,   // lamp off, lead time before signals drop
      ST_DROP = 3'd6    // signals off, supply still on for one cycle
   } pps_state_e;
endpackage

// File: rtl/pps_ms_timer.sv
module pps_ms_timer #(
   parameter int CLKS_PER_MS = 1000,
   parameter int MS_W        = 8
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            clr,
   input  logic [MS_W-1:0] target,
   output logic            expired
);
   logic            tick;
   logic [MS_W-1:0] ms_q;

   generate
      if (CLKS_PER_MS == 1) begin : g_direct
         assign tick = 1'b1;
      end else begin : g_presc
         localparam int PW = $clog2(CLKS_PER_MS);
         localparam logic [PW-1:0] LAST = PW'(CLKS_PER_MS - 1);
         logic [PW-1:0] pre_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                   pre_q <= '0;
            else if (clr || pre_q == LAST) pre_q <= '0;
            else                          pre_q <= pre_q + 1'b1;
         end
         assign tick = (pre_q == LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                    ms_q <= '0;
      else if (clr)                  ms_q <= '0;
      else if (tick && ms_q != '1)   ms_q <= ms_q + 1'b1;
   end

   assign expired = (ms_q >= target);
endmodule

// File: rtl/pps_fsm.sv
module pps_fsm
   import pps_pkg::*;
#(
   parameter int MS_W      = 8,
   parameter int T_RISE    = 10,
   parameter int T_LAMP_ON = 180,
   parameter int T_LEAD    = 100,
   parameter int T_OFF     = 150
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            on_req,
   input  logic            off_req,
   input  logic            supply_good,
   input  logic            expired,
   output pps_state_e      state,
   output logic            tmr_clr,
   output logic [MS_W-1:0] target,
   output logic            fault
);
   pps_state_e state_q, nxt;
   logic       fault_set, fault_clr;

   always_comb begin
      nxt = state_q;
      unique case (state_q)
         ST_HOLD: if (expired)          nxt = ST_IDLE;
         ST_IDLE: if (on_req && !off_req) nxt = ST_RAMP;
         ST_RAMP: begin
            if (off_req)          nxt = ST_HOLD;
            else if (supply_good) nxt = ST_SIGW;
            else if (expired)     nxt = ST_HOLD;
         end
         ST_SIGW: begin
            if (off_req)          nxt = ST_DROP;
            else if (expired)     nxt = ST_ON;
         end
         ST_ON:   if (off_req)    nxt = ST_LOFF;
         ST_LOFF: if (expired)    nxt = ST_DROP;
         ST_DROP:                 nxt = ST_HOLD;
         default:                 nxt = ST_HOLD;
      endcase
   end

   always_comb begin
      unique case (state_q)
         ST_HOLD: target = MS_W'(T_OFF);
         ST_RAMP: target = MS_W'(T_RISE);
         ST_SIGW: target = MS_W'(T_LAMP_ON);
         ST_LOFF: target = MS_W'(T_LEAD);
         default: target = '0;
      endcase
   end

   assign fault_set = (state_q == ST_RAMP) && !off_req && !supply_good && expired;
   assign fault_clr = (state_q == ST_IDLE) && (nxt == ST_RAMP);
   assign tmr_clr   = (nxt != state_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_HOLD;
         fault   <= 1'b0;
      end else begin
         state_q <= nxt;
         if (fault_set)      fault <= 1'b1;
         else if (fault_clr) fault <= 1'b0;
      end
   end

   assign state = state_q;
endmodule

// File: rtl/pps_outdec.sv
module pps_outdec
   import pps_pkg::*;
(
   input  pps_state_e state,
   output logic       vdd_en,
   output logic       sig_en,
   output logic       lamp_en
);
   always_comb begin
      vdd_en  = 1'b0;
      sig_en  = 1'b0;
      lamp_en = 1'b0;
      unique case (state)
         ST_RAMP, ST_DROP: vdd_en = 1'b1;
         ST_SIGW, ST_LOFF: begin
            vdd_en = 1'b1;
            sig_en = 1'b1;
         end
         ST_ON: begin
            vdd_en  = 1'b1;
            sig_en  = 1'b1;
            lamp_en = 1'b1;
         end
         default: ;
      endcase
   end
endmodule

// File: rtl/panel_pwr_seq.sv
module panel_pwr_seq
   import pps_pkg::*;
#(
   parameter int CLK_KHZ          = 100000,
   parameter int SUPPLY_RISE_MS   = 10,
   parameter int LAMP_ON_DLY_MS   = 180,
   parameter int LAMP_OFF_LEAD_MS = 100,
   parameter int VDD_OFF_MIN_MS   = 150
) (
   input  logic clk,
   input  logic rst_n,
   input  logic pwr_on_req,
   input  logic pwr_off_req,
   input  logic supply_good,
   output logic vdd_en,
   output logic sig_en,
   output logic lamp_en,
   output logic fault
);
   localparam int MAX_A  = (SUPPLY_RISE_MS > LAMP_ON_DLY_MS) ? SUPPLY_RISE_MS : LAMP_ON_DLY_MS;
   localparam int MAX_B  = (LAMP_OFF_LEAD_MS > VDD_OFF_MIN_MS) ? LAMP_OFF_LEAD_MS : VDD_OFF_MIN_MS;
   localparam int MAX_MS = (MAX_A > MAX_B) ? MAX_A : MAX_B;
   localparam int MS_W   = $clog2(MAX_MS + 2);

   if (CLK_KHZ < 1) begin : g_bad_clk
      $error("CLK_KHZ must be at least 1");
   end
   if (SUPPLY_RISE_MS < 1 || LAMP_ON_DLY_MS < 1 || LAMP_OFF_LEAD_MS < 1 || VDD_OFF_MIN_MS < 1) begin : g_bad_dly
      $error("every delay must be at least one millisecond");
   end

   pps_state_e      state;
   logic            tmr_clr, expired;
   logic [MS_W-1:0] target;

   pps_ms_timer #(.CLKS_PER_MS(CLK_KHZ), .MS_W(MS_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .target(target), .expired(expired)
   );

   pps_fsm #(
      .MS_W(MS_W), .T_RISE(SUPPLY_RISE_MS), .T_LAMP_ON(LAMP_ON_DLY_MS),
      .T_LEAD(LAMP_OFF_LEAD_MS), .T_OFF(VDD_OFF_MIN_MS)
   ) u_fsm (
      .clk(clk), .rst_n(rst_n), .on_req(pwr_on_req), .off_req(pwr_off_req),
      .supply_good(supply_good), .expired(expired), .state(state),
      .tmr_clr(tmr_clr), .target(target), .fault(fault)
   );

   pps_outdec u_dec (
      .state(state), .vdd_en(vdd_en), .sig_en(sig_en), .lamp_en(lamp_en)
   );
endmodule

// File: rtl/pps_checker.sv
module pps_checker #(
   parameter int CPM  = 1,
   parameter int LON  = 1,
   parameter int LOFF = 1,
   parameter int TOFF = 1
) (
   input logic clk,
   input logic rst_n,
   input logic pwr_on_req,
   input logic supply_good,
   input logic vdd_en,
   input logic sig_en,
   input logic lamp_en,
   input logic fault
);
   localparam int unsigned CAP = 32'd1_000_000_000;
   int unsigned sig_cnt, gap_cnt, off_cnt;
   logic        armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sig_cnt <= 0;
         gap_cnt <= 0;
         off_cnt <= 0;
         armed   <= 1'b0;
      end else begin
         sig_cnt <= !sig_en ? 0 : (sig_cnt < CAP ? sig_cnt + 1 : sig_cnt);
         off_cnt <= vdd_en  ? 0 : (off_cnt < CAP ? off_cnt + 1 : off_cnt);
         if (lamp_en) begin
            armed   <= 1'b1;
            gap_cnt <= 0;
         end else if (!sig_en) begin
            armed   <= 1'b0;
            gap_cnt <= 0;
         end else if (armed && gap_cnt < CAP) begin
            gap_cnt <= gap_cnt + 1;
         end
      end
   end

   AST_VDD_ON_REQ: assert property (@(posedge clk) disable iff (!rst_n) $rose(vdd_en) |-> $past(pwr_on_req)); // R2
   AST_SIG_NEEDS_VDD: assert property (@(posedge clk) disable iff (!rst_n) sig_en |-> vdd_en); // R3
   AST_SIG_AFTER_GOOD: assert property (@(posedge clk) disable iff (!rst_n) $rose(sig_en) |-> $past(supply_good)); // R3
   AST_LAMP_NEEDS_SIG: assert property (@(posedge clk) disable iff (!rst_n) lamp_en |-> sig_en); // R4
   AST_LAMP_ON_DELAY: assert property (@(posedge clk) disable iff (!rst_n) $rose(lamp_en) |-> sig_cnt >= LON * CPM); // R4
   AST_LAMP_OFF_LEAD: assert property (@(posedge clk) disable iff (!rst_n) ($fell(sig_en) && armed) |-> gap_cnt >= LOFF * CPM); // R5
   AST_SIG_BEFORE_VDD: assert property (@(posedge clk) disable iff (!rst_n) $fell(vdd_en) |-> $past(!sig_en)); // R6
   AST_VDD_OFF_TIME: assert property (@(posedge clk) disable iff (!rst_n) $rose(vdd_en) |-> off_cnt >= TOFF * CPM); // R7
   AST_FAULT_SUPPLY_OFF: assert property (@(posedge clk) disable iff (!rst_n) fault |-> !vdd_en); // R8
endmodule

bind panel_pwr_seq pps_checker #(
   .CPM(CLK_KHZ), .LON(LAMP_ON_DLY_MS), .LOFF(LAMP_OFF_LEAD_MS), .TOFF(VDD_OFF_MIN_MS)
) u_pps_checker (
   .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .supply_good(supply_good),
   .vdd_en(vdd_en), .sig_en(sig_en), .lamp_en(lamp_en), .fault(fault)
);

// File: tb/panel_pwr_seq_bench.sv
module panel_pwr_seq_bench;
   localparam int CPM   = 2;
   localparam int RISE  = 3;
   localparam int LON   = 5;
   localparam int LOFF  = 4;
   localparam int TOFF  = 6;
   localparam int SG_DLY = 2;

   localparam int D_RAMP  = SG_DLY;
   localparam int D_SIGW  = LON * CPM + 1;
   localparam int D_LOFF  = LOFF * CPM + 1;
   localparam int D_OFFRQ = TOFF * CPM + 2;
   localparam int D_RST   = TOFF * CPM + 1;
   localparam int D_TMO   = RISE * CPM + 1;

   // table: action (0 none, 1 on pulse, 2 off pulse, 3 hold on request), pattern {vdd,sig,lamp}, dwell (-1 = steady)
   localparam int ROW_N = 11;
   localparam int ROW_ACT [ROW_N] = '{1, 0, 0, 2, 0, 3, 0, 0, 0, 2, 0};
   localparam logic [2:0] ROW_PAT [ROW_N] = '{3'b100, 3'b110, 3'b111, 3'b110, 3'b100, 3'b000,
                                              3'b100, 3'b110, 3'b111, 3'b110, 3'b100};
   localparam int ROW_DW [ROW_N] = '{D_RAMP, D_SIGW, -1, D_LOFF, 1, D_OFFRQ, D_RAMP, D_SIGW, -1, D_LOFF, 1};

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic pwr_on_req = 1'b0;
   logic pwr_off_req = 1'b0;
   logic supply_good = 1'b0;
   logic vdd_en, sig_en, lamp_en, fault;
   logic sg_block = 1'b0;
   int   sg_cnt = 0;
   int   total = 0;
   int   bad = 0;
   logic done = 1'b0;

   always #2.5 clk = ~clk;

   panel_pwr_seq #(
      .CLK_KHZ(CPM), .SUPPLY_RISE_MS(RISE), .LAMP_ON_DLY_MS(LON),
      .LAMP_OFF_LEAD_MS(LOFF), .VDD_OFF_MIN_MS(TOFF)
   ) u_panel_pwr_seq (
      .clk(clk), .rst_n(rst_n), .pwr_on_req(pwr_on_req), .pwr_off_req(pwr_off_req),
      .supply_good(supply_good), .vdd_en(vdd_en), .sig_en(sig_en), .lamp_en(lamp_en),
      .fault(fault)
   );

   // supply model: good SG_DLY samples after the enable, unless blocked
   always @(negedge clk) begin
      if (!vdd_en) begin
         sg_cnt <= 0;
         supply_good <= 1'b0;
      end else begin
         sg_cnt <= sg_cnt + 1;
         supply_good <= (sg_cnt + 1 >= SG_DLY) && !sg_block;
      end
   end

   function automatic logic [2:0] pat();
      return {vdd_en, sig_en, lamp_en};
   endfunction

   function automatic string row_req(input int i);
      case (i)
         0, 6:  return "R2";
         1, 7:  return "R4";
         2, 8:  return "R3";
         3, 9:  return "R5";
         4, 10: return "R6";
         default: return "R7";
      endcase
   endfunction

   task automatic chk(input string req, input int act, input int exp);
      total++;
      if (act != exp) begin
         bad++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic dwell(input logic [2:0] p, output int n);
      n = 0;
      while (pat() == p && n < 300) begin
         n++;
         @(negedge clk);
      end
   endtask

   task automatic pulse_on();
      pwr_on_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0;
   endtask

   task automatic pulse_off();
      pwr_off_req = 1'b1;
      @(negedge clk);
      pwr_off_req = 1'b0;
   endtask

   task automatic wait_pat(input logic [2:0] p);
      for (int k = 0; k < 200 && pat() != p; k++) @(negedge clk);
   endtask

   initial begin
      int n;
      int m;
      int hi;
      // R1: reset state
      sg_block = 1'b1;
      repeat (3) @(negedge clk);
      chk("R1", int'(pat()), 0);
      chk("R1", int'(fault), 0);
      rst_n = 1'b1;
      pwr_on_req = 1'b1;
      @(negedge clk);
      dwell(3'b000, n);
      pwr_on_req = 1'b0;
      chk("R1", n, D_RST);
      chk("R2", int'(pat()), 3'b100);
      // R9: abort during ramp
      pulse_off();
      chk("R9", int'(pat()), 3'b000);
      chk("R9", int'(fault), 0);
      sg_block = 1'b0;
      repeat (20) @(negedge clk);

      // main table
      for (int i = 0; i < ROW_N; i++) begin
         if (ROW_ACT[i] == 1) pulse_on();
         else if (ROW_ACT[i] == 2) pulse_off();
         else if (ROW_ACT[i] == 3) pwr_on_req = 1'b1;
         if (ROW_DW[i] < 0) begin
            chk(row_req(i), int'(pat()), int'(ROW_PAT[i]));
            repeat (4) @(negedge clk);
            chk(row_req(i), int'(pat()), int'(ROW_PAT[i]));
         end else begin
            chk(row_req(i), int'(pat()), int'(ROW_PAT[i]));
            dwell(ROW_PAT[i], n);
            pwr_on_req = 1'b0;
            chk(row_req(i), n, ROW_DW[i]);
         end
      end

      // R7: on pulse during hold is dropped
      @(negedge clk);
      pulse_on();
      hi = 0;
      for (int k = 0; k < 30; k++) begin
         if (vdd_en) hi++;
         @(negedge clk);
      end
      chk("R7", hi, 0);

      // R11: on and off together in idle
      pwr_on_req = 1'b1;
      pwr_off_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0;
      pwr_off_req = 1'b0;
      hi = 0;
      for (int k = 0; k < 3; k++) begin
         if (vdd_en) hi++;
         @(negedge clk);
      end
      chk("R11", hi, 0);

      // R11: requests during shutdown
      pulse_on();
      wait_pat(3'b111);
      pulse_off();
      chk("R5", int'(pat()), 3'b110);
      pwr_on_req = 1'b1;
      pwr_off_req = 1'b1;
      @(negedge clk);
      pwr_on_req = 1'b0;
      pwr_off_req = 1'b0;
      dwell(3'b110, m);
      chk("R11", m + 1, D_LOFF);
      chk("R6", int'(pat()), 3'b100);
      pulse_on();
      chk("R11", int'(pat()), 3'b000);
      hi = 0;
      for (int k = 0; k < 30; k++) begin
         if (vdd_en) hi++;
         @(negedge clk);
      end
      chk("R11", hi, 0);

      // R10: abort while waiting for the lamp
      pulse_on();
      wait_pat(3'b110);
      pulse_off();
      chk("R10", int'(pat()), 3'b100);
      @(negedge clk);
      chk("R10", int'(pat()), 3'b000);
      repeat (20) @(negedge clk);

      // R8: supply never good
      sg_block = 1'b1;
      pulse_on();
      dwell(3'b100, n);
      chk("R8", n, D_TMO);
      chk("R8", int'(pat()), 3'b000);
      chk("R8", int'(fault), 1);
      repeat (20) @(negedge clk);
      chk("R8", int'(fault), 1);
      sg_block = 1'b0;
      pulse_on();
      chk("R8", int'(fault), 0);
      chk("R8", int'(pat()), 3'b100);
      dwell(3'b100, n);
      chk("R3", n, D_RAMP);

      $display("test done: total=%0d bad=%0d", total, bad);
      done = 1'b1;
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=expired expected=finished");
         $display("test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end
endmodule